// File: doc/BRIEF.md
# Wide-Word Group Swap and Bit-Reversal Unit

This block permutes a wide data word by swapping neighbouring groups of bits. A single swap step of level s exchanges every aligned group of 2^(s-1) bits with the group beside it. The swap is built only from three parts: an alternating-mask generator, a pair of shifts in opposite directions, and a per-bit masked merge. Running every level from 1 to log2(W) in turn reverses the bit order of the word, and the unit can do that on its own as a multi-cycle command.

The masked merge is also available as a separate command. It builds the result bit by bit from two input words under a mask. Two override inputs take the whole word from one input, whatever the mask says. A command is issued by pulsing `start_i` with an operation code. The result appears on `result_o` in the cycle in which `done_o` is high, and it stays there until the next accepted command.

Top module: `wshuf_top`

## Requirements
- R1: After reset `done_o` and `busy_o` are low and `result_o` is all zeros.
- R2: A start with op code 0 (single swap) and a level s between 1 and log2(W) gives a result in which bit i equals `data_i` bit (i XOR 2^(s-1)). This result appears with `done_o` in the cycle after the start edge.
- R3: A single swap with level 0, or with a level above log2(W), returns `data_i` unchanged one cycle after the start edge.
- R4: A start with op code 1 (full reverse) gives a result in which bit i equals `data_i` bit W-1-i. `done_o` rises log2(W) clock edges after the start edge, one level being applied per cycle.
- R5: `done_o` is high for exactly one cycle for each accepted command of op code 0, 1 or 2, and is low otherwise.
- R6: `busy_o` is high from the cycle after a full-reverse start until the cycle before its `done_o`, and `done_o` is never high while `busy_o` is high. Any start while `busy_o` is high is ignored, and so is a start with op code 3.
- R7: A start with op code 2 (merge), with both overrides low, gives a result in which bit i is `alt_i` bit i where `mask_i` bit i is 1 and `data_i` bit i where it is 0. The result appears one cycle after the start edge.
- R8: In a merge, `ovr_a_i` high makes the whole result `data_i`. `ovr_b_i` high, with `ovr_a_i` low, makes it `alt_i`. `ovr_a_i` wins when both are high.
- R9: While no command is running or being accepted, `result_o` holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command strobe, taken only when not busy |
| op_i | input | 2 | 0 single swap, 1 full reverse, 2 merge, 3 no operation |
| stage_i | input | clog2(log2(W)+1) | Swap level for op code 0 |
| data_i | input | W | Operand word; first merge input |
| alt_i | input | W | Second merge input |
| mask_i | input | W | Merge selection mask, 1 picks `alt_i` |
| ovr_a_i | input | 1 | Merge override: take all bits from `data_i` |
| ovr_b_i | input | 1 | Merge override: take all bits from `alt_i` |
| busy_o | output | 1 | Full reverse in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | W | Result word, held between commands |

## Verification
The hardest cases to reach from the ports are the middle steps of a full reverse. During those cycles the unit feeds its own partial word back through the swap path, and a start that arrives then must be dropped without disturbing the run. The stimulus issues a reverse and then keeps `start_i` high with other op codes on the next few cycles. Separately, it chains single swaps of every level on one word, so the same path is also exercised from the outside, level by level. The reference model predicts `done_o`, `busy_o` and the held result on every cycle, so a stray accepted start shows up as a mismatch.

// File: rtl/wshuf_pkg.sv
package wshuf_pkg;
   typedef enum logic [1:0] {
      WS_STAGE   = 2'd0,
      WS_REVERSE = 2'd1,
      WS_MERGE   = 2'd2,
      WS_NOP     = 2'd3
   } ws_op_e;
endpackage

// File: rtl/wshuf_mask_gen.sv
// Alternating group mask for a swap level: bit i is set when bit (s-1) of i is set.
module wshuf_mask_gen #(
   parameter int W     = 32,
   parameter int LOG2W = $clog2(W),
   parameter int SW    = $clog2(LOG2W + 1)
) (
   input  logic [SW-1:0]    stage_i,
   output logic [W-1:0]     mask_o,
   output logic [LOG2W-1:0] grp_o,
   output logic             valid_o
);
   logic [W-1:0] pat [LOG2W];

   for (genvar k = 0; k < LOG2W; k++) begin : g_level
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign pat[k][i] = 1'((i >> k) & 1);
      end
   end

   always_comb begin
      mask_o  = '0;
      grp_o   = '0;
      valid_o = 1'b0;
      for (int k = 0; k < LOG2W; k++) begin
         if (stage_i == SW'(k + 1)) begin
            mask_o  = pat[k];
            grp_o   = LOG2W'(1 << k);
            valid_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/wshuf_merge.sv
// Per-bit two-input select with whole-word overrides (force_a wins).
module wshuf_merge #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] mask_i,
   input  logic         force_a_i,
   input  logic         force_b_i,
   output logic [W-1:0] y_o
);
   logic [W-1:0] sel;

   always_comb begin
      if (force_a_i)      sel = '0;
      else if (force_b_i) sel = '1;
      else                sel = mask_i;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign y_o[i] = sel[i] ? b_i[i] : a_i[i];
   end
endmodule

// File: rtl/wshuf_swap_stage.sv
// One group-swap level: masked halves shifted opposite ways, then merged.
module wshuf_swap_stage #(
   parameter int W     = 32,
   parameter int LOG2W = $clog2(W),
   parameter int SW    = $clog2(LOG2W + 1)
) (
   input  logic [W-1:0]  x_i,
   input  logic [SW-1:0] stage_i,
   output logic [W-1:0]  y_o
);
   logic [W-1:0]     mask;
   logic [LOG2W-1:0] grp;
   logic             valid;
   logic [W-1:0]     down_sh, up_sh, merged;

   wshuf_mask_gen #(.W(W), .LOG2W(LOG2W), .SW(SW)) mgen_i (
      .stage_i (stage_i),
      .mask_o  (mask),
      .grp_o   (grp),
      .valid_o (valid)
   );

   // Upper groups move down, lower groups move up.
   assign down_sh = (x_i & mask) >> grp;
   assign up_sh   = (x_i & ~mask) << grp;

   wshuf_merge #(.W(W)) mrg_i (
      .a_i       (down_sh),
      .b_i       (up_sh),
      .mask_i    (mask),
      .force_a_i (1'b0),
      .force_b_i (1'b0),
      .y_o       (merged)
   );

   assign y_o = valid ? merged : x_i;
endmodule

// File: rtl/wshuf_top.sv
module wshuf_top
   import wshuf_pkg::*;
#(
   parameter  int W     = 32,
   localparam int LOG2W = $clog2(W),
   localparam int SW    = $clog2(LOG2W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [1:0]    op_i,
   input  logic [SW-1:0] stage_i,
   input  logic [W-1:0]  data_i,
   input  logic [W-1:0]  alt_i,
   input  logic [W-1:0]  mask_i,
   input  logic          ovr_a_i,
   input  logic          ovr_b_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [W-1:0]  result_o
);
   if (W < 2 || (1 << LOG2W) != W) begin : g_bad_width
      $error("wshuf_top: W must be a power of two of at least 2");
   end

   ws_op_e        op;
   logic          accept;
   logic [W-1:0]  work_q, swap_x, swap_y, merge_y;
   logic [SW-1:0] step_q, swap_stage;
   logic          busy_q, done_q;

   assign op     = ws_op_e'(op_i);
   assign accept = start_i && !busy_q;

   // The single swap level is shared by every step of a full reverse.
   always_comb begin
      if (busy_q) begin
         swap_x     = work_q;
         swap_stage = step_q;
      end else begin
         swap_x     = data_i;
         swap_stage = (op == WS_REVERSE) ? SW'(1) : stage_i;
      end
   end

   wshuf_swap_stage #(.W(W), .LOG2W(LOG2W), .SW(SW)) swap_i (
      .x_i     (swap_x),
      .stage_i (swap_stage),
      .y_o     (swap_y)
   );

   wshuf_merge #(.W(W)) merge_i (
      .a_i       (data_i),
      .b_i       (alt_i),
      .mask_i    (mask_i),
      .force_a_i (ovr_a_i),
      .force_b_i (ovr_b_i),
      .y_o       (merge_y)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         work_q <= '0;
         step_q <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (busy_q) begin
         work_q <= swap_y;
         if (step_q == SW'(LOG2W)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            step_q <= step_q + SW'(1);
            done_q <= 1'b0;
         end
      end else if (accept) begin
         unique case (op)
            WS_STAGE: begin
               work_q <= swap_y;
               done_q <= 1'b1;
            end
            WS_REVERSE: begin
               work_q <= swap_y;
               if (LOG2W == 1) begin
                  done_q <= 1'b1;
               end else begin
                  busy_q <= 1'b1;
                  step_q <= SW'(2);
                  done_q <= 1'b0;
               end
            end
            WS_MERGE: begin
               work_q <= merge_y;
               done_q <= 1'b1;
            end
            default: done_q <= 1'b0;
         endcase
      end else begin
         done_q <= 1'b0;
      end
   end

   assign busy_o   = busy_q;
   assign done_o   = done_q;
   assign result_o = work_q;
endmodule

// File: rtl/wshuf_checker.sv
module wshuf_checker #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic [1:0]   op_i,
   input logic         ovr_a_i,
   input logic [W-1:0] data_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [W-1:0] result_o
);
   p_stage_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && op_i == 2'd0) |=> done_o);

   p_rev_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && op_i == 2'd1) |=> (busy_o || done_o));

   p_busy_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !done_o);

   p_force_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && op_i == 2'd2 && ovr_a_i) |=> (result_o == $past(data_i)));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(result_o));
endmodule

bind wshuf_top wshuf_checker #(.W(W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .op_i     (op_i),
   .ovr_a_i  (ovr_a_i),
   .data_i   (data_i),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .result_o (result_o)
);

// File: tb/wshuf_top_tb_top.sv
`timescale 1ns/1ps
module wshuf_top_tb_top;
   localparam int W     = 32;
   localparam int LOG2W = $clog2(W);
   localparam int SW    = $clog2(LOG2W + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [1:0]    op_i = '0;
   logic [SW-1:0] stage_i = '0;
   logic [W-1:0]  data_i = '0, alt_i = '0, mask_i = '0;
   logic          ovr_a_i = 1'b0, ovr_b_i = 1'b0;
   logic          busy_o, done_o;
   logic [W-1:0]  result_o;

   always #2 clk = ~clk;

   wshuf_top #(.W(W)) dut_i (.*);

   int checks = 0, failures = 0, cycles = 0;
   bit finished = 0;

   // Reference model state
   int           m_cnt = 0;
   bit           m_done = 0;
   logic [W-1:0] m_res = '0, m_pend = '0;
   string        m_tag = "R1";

   function automatic logic [W-1:0] ref_stage(logic [W-1:0] x, int s);
      logic [W-1:0] y;
      if (s < 1 || s > LOG2W) return x;
      for (int i = 0; i < W; i++) y[i] = x[i ^ (1 << (s - 1))];
      return y;
   endfunction

   function automatic logic [W-1:0] ref_rev(logic [W-1:0] x);
      logic [W-1:0] y;
      for (int i = 0; i < W; i++) y[i] = x[W-1-i];
      return y;
   endfunction

   function automatic logic [W-1:0] ref_merge(logic [W-1:0] a, logic [W-1:0] b,
                                              logic [W-1:0] m, bit fa, bit fb);
      logic [W-1:0] y;
      for (int i = 0; i < W; i++) begin
         if (fa)      y[i] = a[i];
         else if (fb) y[i] = b[i];
         else         y[i] = m[i] ? b[i] : a[i];
      end
      return y;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_done = 0; m_res = '0; m_tag = "R1";
      end else begin
         m_done = 0;
         if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin m_done = 1; m_res = m_pend; end
         end else if (start_i) begin
            case (op_i)
               2'd0: begin
                  m_res  = ref_stage(data_i, int'(stage_i));
                  m_done = 1;
                  m_tag  = (stage_i >= 1 && int'(stage_i) <= LOG2W) ? "R2" : "R3";
               end
               2'd1: begin
                  m_pend = ref_rev(data_i);
                  m_cnt  = LOG2W - 1;
                  m_tag  = "R4";
                  if (m_cnt == 0) begin m_done = 1; m_res = m_pend; end
               end
               2'd2: begin
                  m_res  = ref_merge(data_i, alt_i, mask_i, ovr_a_i, ovr_b_i);
                  m_done = 1;
                  m_tag  = (ovr_a_i || ovr_b_i) ? "R8" : "R7";
               end
               default: m_tag = "R9";
            endcase
         end else begin
            m_tag = "R9";
         end
      end
   end

   // Compare away from the active edge.
   always @(negedge clk) begin
      if (!finished) begin
         checks++;
         if (done_o !== m_done) begin
            failures++;
            $display("FAIL R5 done_o actual=%0b expected=%0b", done_o, m_done);
         end
         checks++;
         if (busy_o !== (m_cnt > 0)) begin
            failures++;
            $display("FAIL R6 busy_o actual=%0b expected=%0b", busy_o, (m_cnt > 0));
         end
         if (m_cnt == 0) begin
            checks++;
            if (result_o !== m_res) begin
               failures++;
               $display("FAIL %s result_o actual=%h expected=%h", m_tag, result_o, m_res);
            end
         end
      end
   end

   // Caller is at a negedge; start is held for one cycle.
   task automatic cmd(input logic [1:0] op, input int stg, input logic [W-1:0] d,
                      input logic [W-1:0] a, input logic [W-1:0] m, input bit fa, input bit fb);
      start_i = 1'b1; op_i = op; stage_i = SW'(stg);
      data_i = d; alt_i = a; mask_i = m; ovr_a_i = fa; ovr_b_i = fb;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
         finish_run();
      end
   end

   initial begin
      logic [W-1:0] w;
      idle(3);
      // R1: reset values are compared while rst_n is low and just after.
      rst_n = 1'b1;
      idle(2);
      // R2 and R3: every level code, several patterns.
      for (int s = 0; s < (1 << SW); s++) begin
         cmd(2'd0, s, 32'h0123_4567, '0, '0, 0, 0);
         cmd(2'd0, s, 32'h8000_0001, '0, '0, 0, 0);
         cmd(2'd0, s, $urandom, '0, '0, 0, 0);
      end
      idle(1);
      // R2 chained levels give a full reversal through the ports.
      w = 32'hDEAD_BEEF;
      for (int s = 1; s <= LOG2W; s++) begin
         cmd(2'd0, s, w, '0, '0, 0, 0);
         w = result_o;
      end
      idle(1);
      // R4: full reverse on assorted words.
      cmd(2'd1, 0, 32'h0000_0001, '0, '0, 0, 0); idle(LOG2W + 1);
      cmd(2'd1, 0, 32'hF0F0_1234, '0, '0, 0, 0); idle(LOG2W);
      cmd(2'd1, 0, $urandom, '0, '0, 0, 0);      idle(LOG2W + 2);
      // R6: starts during a reverse are ignored.
      cmd(2'd1, 0, 32'h1357_9BDF, '0, '0, 0, 0);
      cmd(2'd2, 0, 32'hFFFF_FFFF, '0, '0, 1, 0);
      cmd(2'd0, 1, 32'hAAAA_AAAA, '0, '0, 0, 0);
      cmd(2'd1, 0, 32'h5555_0000, '0, '0, 0, 0);
      idle(LOG2W + 1);
      // R6: op code 3 ignored, R9 hold.
      cmd(2'd3, 2, 32'hCAFE_F00D, '0, '0, 0, 0);
      idle(3);
      // R7: merge with masks.
      cmd(2'd2, 0, 32'h1111_1111, 32'hEEEE_EEEE, 32'hFF00_FF00, 0, 0);
      cmd(2'd2, 0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 0, 0);
      cmd(2'd2, 0, $urandom, $urandom, $urandom, 0, 0);
      // R8: overrides.
      cmd(2'd2, 0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F, 1, 0);
      cmd(2'd2, 0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F, 0, 1);
      cmd(2'd2, 0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F, 1, 1);
      idle(2);
      // Random mix including back-to-back commands.
      for (int n = 0; n < 200; n++) begin
         cmd(2'($urandom_range(0, 3)), $urandom_range(0, (1 << SW) - 1),
             $urandom, $urandom, $urandom, 1'($urandom), 1'($urandom));
         if ($urandom_range(0, 3) == 0) idle($urandom_range(0, LOG2W + 1));
      end
      idle(LOG2W + 2);
      // R1: reset mid-run clears everything.
      cmd(2'd1, 0, 32'hFFFF_0000, '0, '0, 0, 0);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(2);
      finish_run();
   end
endmodule